// File: doc/BRIEF.md
# Soft Mute Gain Ramp Sequencer

This block drives the gain codes of two audio output stages, a headphone stage and a converter stage, and walks each code one step at a time whenever software flips that stage's mute bit. Muting walks the code down to 0, which is fully silent. Unmuting walks it up to a target code supplied from outside the block. A free-running divider paces the ramp at one code step per tick.

When a ramp finishes, the block raises a completion flag in a 7-bit flag register. Three more flags are set by event pulses from the analog side. A mask register and a form register decide how the flags drive a single level interrupt line.

Software talks to the block through a byte-write port. A 3-bit select picks the register:
- 0 is headphone control.
- 1 is converter control.
- 2 is the flag byte.
- 3 is the mask byte.
- 4 is the form byte.

Top module: `mute_ramp_seq`

## Requirements
- R1: After reset, both gain outputs are 0, all flags are clear, all seven mask bits are set, the form field is 00, and `irq` is low.
- R2: Writing select 0 with bit 7 = 0 while the headphone mute is set starts a ramp. The ramp moves `hp_gain` by one code per tick toward `hp_target`. On the tick after it gets there, flag bit 3 is set.
- R3: Writing select 0 with bit 7 = 1 while the headphone is unmuted moves `hp_gain` one code per tick down to 0. On the tick after it gets there, flag bit 2 is set.
- R4: On select 1, bit 7 is the converter mute. Unmuting ramps `dac_gain` to `dac_target` and then sets flag bit 1. Muting ramps it to 0 and then sets flag bit 0.
- R5: A select 1 write whose bit 4 (standby) is 1 starts no ramp, even if it changes the mute bit. `dac_gain` keeps its value and no flag is set.
- R6: A mute change that arrives during a ramp reverses the ramp from the current gain. The abandoned direction raises no completion flag.
- R7: Writing select 2 clears every flag whose data bit is 1 and leaves the others alone. A flag that is set in the same cycle as it is cleared stays set.
- R8: A high on `ext_evt[0]`, `ext_evt[1]` or `ext_evt[2]` sets flag bit 4 (short circuit), bit 5 (jack) or bit 6 (short-circuit release) respectively.
- R9: Select 3 writes the mask from data bits 6:0. A set mask bit keeps the flag at the same position out of the interrupt. The interrupt is pending when any unmasked flag is set.
- R10: Select 4 writes the form from data bits 7:6. With form 00, `irq` is active-high (`irq` equals pending). With any other form value, `irq` is the inverse of pending.
- R11: Writes on selects 5 to 7 change no state.
- R12: The gain changes only on a tick, which comes once every `TICK_DIV` (64) clocks counted from reset. A ramp whose gain already equals its end code finishes on its first tick without moving the gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 headphone, 1 converter, 2 flags, 3 mask, 4 form) |
| wr_data | input | 8 | Write data byte |
| hp_target | input | 5 | Gain code the headphone ramp ends at when unmuting |
| dac_target | input | 5 | Gain code the converter ramp ends at when unmuting |
| ext_evt | input | 3 | Event pulses that set flags 4, 5 and 6 |
| hp_gain | output | 5 | Current headphone gain code |
| dac_gain | output | 5 | Current converter gain code |
| irq | output | 1 | Level interrupt output |

## Verification
Nearly every internal fault reaches the ports within one tick period:
- A wrong divider phase moves a gain code on the wrong cycle.
- A lost ramp direction sends a gain the wrong way on the next tick.
- A stuck ramp never sets its flag.

A fault in the flag or mask registers changes `irq` in the cycle right after the write or event that exposes it. The bench isolates each single flag by unmasking only that bit. This lets a missing or misplaced completion flag be seen at `irq` within two clocks of the mask write.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int GAIN_W = 5;
  localparam int FLAG_N = 7;

  typedef enum logic [2:0] {
    SEL_HP   = 3'd0,
    SEL_CONV = 3'd1,
    SEL_FLAG = 3'd2,
    SEL_MASK = 3'd3,
    SEL_FORM = 3'd4
  } wsel_e;

  // Control byte bit positions
  localparam int MUTE_BIT    = 7;
  localparam int STANDBY_BIT = 4;

  // One code toward the end value; holds when equal
  function automatic logic [GAIN_W-1:0] step_toward(input logic [GAIN_W-1:0] g,
                                                    input logic [GAIN_W-1:0] e);
    if (g < e)      return g + 1'b1;
    else if (g > e) return g - 1'b1;
    else            return g;
  endfunction
endpackage

// File: rtl/mrs_tick_div.sv
module mrs_tick_div #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mrs_ramp_engine.sv
module mrs_ramp_engine
  import mrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              mute_req,
  input  logic [GAIN_W-1:0] target,
  output logic [GAIN_W-1:0] gain,
  output logic              done_up,
  output logic              done_dn
);
  logic              active_q, down_q;
  logic [GAIN_W-1:0] gain_q, end_code;
  logic              at_end, finish;

  assign end_code = down_q ? '0 : target;
  assign at_end   = (gain_q == end_code);
  assign finish   = tick && active_q && at_end && !start;
  assign done_up  = finish && !down_q;
  assign done_dn  = finish && down_q;
  assign gain     = gain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      down_q   <= 1'b1;
      gain_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      down_q   <= mute_req;
    end else if (tick && active_q) begin
      if (at_end) active_q <= 1'b0;
      else        gain_q   <= step_toward(gain_q, end_code);
    end
  end
endmodule

// File: rtl/mrs_irq_flags.sv
module mrs_irq_flags
  import mrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] set_vec,
  input  logic              clr_wr,
  input  logic              mask_wr,
  input  logic              form_wr,
  input  logic [7:0]        wdata,
  output logic [FLAG_N-1:0] flags,
  output logic [FLAG_N-1:0] mask,
  output logic [1:0]        form,
  output logic              irq
);
  logic [FLAG_N-1:0] clr_vec;
  logic              pending;

  assign clr_vec = clr_wr ? wdata[FLAG_N-1:0] : '0;
  assign pending = |(flags & ~mask);
  assign irq     = (form == 2'b00) ? pending : !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '1;
      form  <= 2'b00;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;
      if (mask_wr) mask <= wdata[FLAG_N-1:0];
      if (form_wr) form <= wdata[7:6];
    end
  end
endmodule

// File: rtl/mute_ramp_seq.sv
module mute_ramp_seq
  import mrs_pkg::*;
#(
  parameter int TICK_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic [GAIN_W-1:0] hp_target,
  input  logic [GAIN_W-1:0] dac_target,
  input  logic [2:0]        ext_evt,
  output logic [GAIN_W-1:0] hp_gain,
  output logic [GAIN_W-1:0] dac_gain,
  output logic              irq
);
  localparam int NCH = 2;  // channel 0 headphone, 1 converter

  logic tick;
  mrs_tick_div #(.DIV(TICK_DIV)) u_div (.clk(clk), .rst_n(rst_n), .tick(tick));

  logic hp_mute_q, cv_mute_q, cv_sb_q;
  logic wr_hp, wr_cv;
  assign wr_hp = wr_en && (wr_sel == SEL_HP);
  assign wr_cv = wr_en && (wr_sel == SEL_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_mute_q <= 1'b1;
      cv_mute_q <= 1'b1;
      cv_sb_q   <= 1'b1;
    end else begin
      if (wr_hp) hp_mute_q <= wr_data[MUTE_BIT];
      if (wr_cv) begin
        cv_mute_q <= wr_data[MUTE_BIT];
        cv_sb_q   <= wr_data[STANDBY_BIT];
      end
    end
  end

  logic [NCH-1:0]    ch_start, ch_up, ch_dn;
  logic [GAIN_W-1:0] ch_tgt  [NCH];
  logic [GAIN_W-1:0] ch_gain [NCH];

  assign ch_start[0] = wr_hp && (wr_data[MUTE_BIT] != hp_mute_q);
  assign ch_start[1] = wr_cv && (wr_data[MUTE_BIT] != cv_mute_q) && !wr_data[STANDBY_BIT];
  assign ch_tgt[0]   = hp_target;
  assign ch_tgt[1]   = dac_target;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      mrs_ramp_engine u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start(ch_start[i]), .mute_req(wr_data[MUTE_BIT]),
        .target(ch_tgt[i]), .gain(ch_gain[i]),
        .done_up(ch_up[i]), .done_dn(ch_dn[i])
      );
    end
  endgenerate

  // Named events for the checker
  logic hp_done_dn, cv_done_dn;
  assign hp_done_dn = ch_dn[0];
  assign cv_done_dn = ch_dn[1];
  assign hp_gain    = ch_gain[0];
  assign dac_gain   = ch_gain[1];

  logic [FLAG_N-1:0] set_vec, flags, mask;
  logic [1:0]        form;
  assign set_vec = {ext_evt, ch_up[0], ch_dn[0], ch_up[1], ch_dn[1]};

  mrs_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_wr(wr_en && (wr_sel == SEL_FLAG)),
    .mask_wr(wr_en && (wr_sel == SEL_MASK)),
    .form_wr(wr_en && (wr_sel == SEL_FORM)),
    .wdata(wr_data), .flags(flags), .mask(mask), .form(form), .irq(irq)
  );
endmodule

// File: rtl/mute_ramp_seq_chk.sv
module mute_ramp_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [4:0] hp_gain,
  input logic [4:0] dac_gain,
  input logic       hp_done_dn,
  input logic       cv_done_dn,
  input logic [2:0] ext_evt,
  input logic [6:0] flags,
  input logic [6:0] mask,
  input logic [1:0] form,
  input logic       irq
);
  // R2
  hp_gain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hp_gain) |-> (({1'b0, hp_gain} == {1'b0, $past(hp_gain)} + 6'd1) ||
                           ({1'b0, $past(hp_gain)} == {1'b0, hp_gain} + 6'd1)));
  // R4
  dac_gain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_gain) |-> (({1'b0, dac_gain} == {1'b0, $past(dac_gain)} + 6'd1) ||
                            ({1'b0, $past(dac_gain)} == {1'b0, dac_gain} + 6'd1)));
  // R12
  gain_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hp_gain) || !$stable(dac_gain)) |-> $past(tick));
  // R3
  hp_down_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hp_done_dn |-> (hp_gain == 5'd0));
  // R4
  cv_down_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cv_done_dn |-> (dac_gain == 5'd0));
  // R8
  jack_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt[1] |=> flags[5]);
  // R9
  irq_all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 7'h7F && form == 2'b00) |-> !irq);
endmodule

bind mute_ramp_seq mute_ramp_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .hp_gain(hp_gain), .dac_gain(dac_gain),
  .hp_done_dn(hp_done_dn), .cv_done_dn(cv_done_dn), .ext_evt(ext_evt),
  .flags(flags), .mask(mask), .form(form), .irq(irq)
);

// File: tb/mute_ramp_seq_bench.sv
module mute_ramp_seq_bench;
  localparam int DIV = 64;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [4:0] hp_target = 5'd5;
  logic [4:0] dac_target = 5'd3;
  logic [2:0] ext_evt = 3'd0;
  logic [4:0] hp_gain, dac_gain;
  logic       irq;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mute_ramp_seq u_mute_ramp_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hp_target(hp_target), .dac_target(dac_target), .ext_evt(ext_evt),
    .hp_gain(hp_gain), .dac_gain(dac_gain), .irq(irq)
  );

  // Behavioural reference model
  int m_cnt, m_hg, m_dg, m_flags, m_mask, m_form;
  bit m_hact, m_hdn, m_dact, m_ddn, m_hm, m_cm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_hg = 0; m_dg = 0; m_flags = 0; m_mask = 127; m_form = 0;
      m_hact = 0; m_hdn = 1; m_dact = 0; m_ddn = 1; m_hm = 1; m_cm = 1;
    end else begin
      bit t;
      int setv, clr, endv, d;
      t = (m_cnt == DIV - 1);
      m_cnt = t ? 0 : m_cnt + 1;
      setv = int'(ext_evt) * 16;
      d = int'(wr_data);
      if (wr_en && wr_sel == 3'd0 && wr_data[7] != m_hm) begin
        m_hact = 1; m_hdn = wr_data[7];
      end else if (t && m_hact) begin
        endv = m_hdn ? 0 : int'(hp_target);
        if (m_hg == endv) begin m_hact = 0; setv = setv | (m_hdn ? 4 : 8); end
        else m_hg = (m_hg < endv) ? m_hg + 1 : m_hg - 1;
      end
      if (wr_en && wr_sel == 3'd1 && wr_data[7] != m_cm && !wr_data[4]) begin
        m_dact = 1; m_ddn = wr_data[7];
      end else if (t && m_dact) begin
        endv = m_ddn ? 0 : int'(dac_target);
        if (m_dg == endv) begin m_dact = 0; setv = setv | (m_ddn ? 1 : 2); end
        else m_dg = (m_dg < endv) ? m_dg + 1 : m_dg - 1;
      end
      if (wr_en && wr_sel == 3'd0) m_hm = wr_data[7];
      if (wr_en && wr_sel == 3'd1) m_cm = wr_data[7];
      clr = (wr_en && wr_sel == 3'd2) ? (d % 128) : 0;
      m_flags = (m_flags & ~clr & 127) | setv;
      if (wr_en && wr_sel == 3'd3) m_mask = d % 128;
      if (wr_en && wr_sel == 3'd4) m_form = d / 64;
    end
  end

  function automatic bit model_irq();
    bit p;
    p = ((m_flags & ~m_mask & 127) != 0);
    return (m_form == 0) ? p : !p;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 R3 hp_gain vs model", int'(hp_gain), m_hg);
    chk("R4 dac_gain vs model", int'(dac_gain), m_dg);
    chk("R9 R10 irq vs model", int'(irq), int'(model_irq()));
  end

  task automatic wr(input int sel, input int data);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(data);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Unmask a single flag and observe it on irq (form 00 assumed)
  task automatic flag_is(input int bitpos, input string tag, input int exp);
    wr(3, 127 - (1 << bitpos));
    wait_cyc(1);
    chk(tag, int'(irq), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int g;
    wait_cyc(3); #1 rst_n = 1'b1;
    wait_cyc(1);
    chk("R1 hp_gain reset", int'(hp_gain), 0);
    chk("R1 dac_gain reset", int'(dac_gain), 0);
    chk("R1 irq reset", int'(irq), 0);
    wr(3, 0);
    chk("R9 no flag pending after unmask", int'(irq), 0);

    // R2 headphone unmute ramp
    wr(0, 8'h00);
    wait_cyc(7 * DIV);
    chk("R2 hp_gain reached target", int'(hp_gain), 5);
    flag_is(3, "R2 ramp-up flag bit3", 1);
    flag_is(2, "R2 ramp-down flag bit2 clear", 0);
    wr(2, 127);
    wr(3, 0);
    chk("R7 all flags cleared", int'(irq), 0);

    // R6 reversal mid-ramp
    wr(0, 8'h80);
    wait_cyc(2 * DIV + 10);
    g = int'(hp_gain);
    chk("R6 hp mid-ramp below 5", int'(g < 5 && g > 0), 1);
    wr(0, 8'h00);
    wait_cyc(7 * DIV);
    chk("R6 hp back at target", int'(hp_gain), 5);
    flag_is(2, "R6 no ramp-down flag after reversal", 0);
    flag_is(3, "R6 ramp-up flag after reversal", 1);
    wr(2, 127);

    // R3 headphone mute ramp
    wr(0, 8'h80);
    wait_cyc(7 * DIV);
    chk("R3 hp_gain reached 0", int'(hp_gain), 0);
    flag_is(2, "R3 ramp-down flag bit2", 1);
    wr(2, 127);

    // R4 converter unmute then mute (standby cleared)
    wr(1, 8'h00);
    wait_cyc(5 * DIV);
    chk("R4 dac_gain at target", int'(dac_gain), 3);
    flag_is(1, "R4 gain-up flag bit1", 1);
    wr(1, 8'h80);
    wait_cyc(5 * DIV);
    chk("R4 dac_gain at 0", int'(dac_gain), 0);
    flag_is(0, "R4 gain-down flag bit0", 1);
    wr(2, 127);

    // R5 standby blocks ramp
    wr(1, 8'h10);
    wait_cyc(5 * DIV);
    chk("R5 dac_gain held in standby", int'(dac_gain), 0);
    flag_is(1, "R5 no gain-up flag in standby", 0);

    // R8 event flags and R7 set-over-clear
    ext_evt = 3'b001; wait_cyc(1); #1 ext_evt = 3'b000;
    flag_is(4, "R8 short-circuit flag bit4", 1);
    ext_evt = 3'b100; wait_cyc(1); #1 ext_evt = 3'b000;
    flag_is(6, "R8 release flag bit6", 1);
    wr(2, 127);
    @(negedge clk); #1;
    ext_evt = 3'b010; wr_en = 1'b1; wr_sel = 3'd2; wr_data = 8'h20;
    @(negedge clk); #1;
    ext_evt = 3'b000; wr_en = 1'b0;
    flag_is(5, "R7 set wins over clear", 1);
    wr(2, 8'h20);
    chk("R7 jack flag cleared", int'(irq), 0);

    // R10 form inversion
    wr(4, 8'h40);
    chk("R10 inverted idle irq high", int'(irq), 1);
    ext_evt = 3'b010; wait_cyc(1); #1 ext_evt = 3'b000;
    wait_cyc(1);
    chk("R10 inverted pending irq low", int'(irq), 0);
    wr(4, 8'h00);
    chk("R10 form 00 pending irq high", int'(irq), 1);
    wr(2, 127);

    // R11 unused selects
    wr(5, 8'h00); wr(6, 8'hFF); wr(7, 8'h00);
    wait_cyc(3 * DIV);
    chk("R11 hp_gain unchanged", int'(hp_gain), 0);
    wr(3, 0);
    chk("R11 no flag from unused select", int'(irq), 0);

    // R12 already at end code: target 0
    hp_target = 5'd0;
    wr(0, 8'h00);
    wait_cyc(2 * DIV);
    chk("R12 hp_gain not moved", int'(hp_gain), 0);
    flag_is(3, "R12 ramp-up flag without movement", 1);

    wait_cyc(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule